// File: doc/BRIEF.md
# Audio Port FIFO Status and Error Interrupt Unit

This unit sits beside the transmit and receive FIFOs of a serial audio port. It tracks how full each FIFO is, and it raises data-request lines when an occupancy threshold set by software is crossed. It detects writes into a full FIFO and reads from an empty one, and it combines the enabled error conditions with the port idle indication into one interrupt line. The FIFO storage and the serial shifter are outside the unit. The unit sees only their push and pop strobes, and it tells them whether each access was accepted.

Software programs the unit through a simple write port. A 3-bit select picks one of five configuration or status words. The status and FIFO status words are always visible on output ports. Sticky flags are cleared by writing zero to their bit positions. After any error, both transfer directions are forced to stop. They can only be restarted once every error flag has been cleared.

Top module: `afu_irq_unit`

## Requirements
- R1: While reset is asserted, both status words read zero, both occupancy counts are zero, both run outputs are low and every request and interrupt output is low.
- R2: Each occupancy count rises by one for an accepted push and falls by one for an accepted pop, and stays the same when both happen in one cycle. The transmit count is shown at FIFO-status bits 29:24 and the receive count at bits 13:8. Transmit pushes come from software and transmit pops from the serial side; for receive it is the other way round. A count never exceeds DEPTH (32).
- R3: A push while the count equals DEPTH is refused: the accept output is low in that cycle and the count does not change. It sets a sticky overflow flag, which is status bit 28 for transmit and bit 26 for receive.
- R4: A pop while the count is zero asserts the zero-fill output in that cycle and leaves the count at zero. It sets a sticky underflow flag, which is status bit 29 for transmit and bit 27 for receive.
- R5: The transmit-empty flag (FIFO-status bit 16) sets one cycle after the transmit count is at or below the transmit threshold. The threshold is held in bits 12:8 of the threshold word at select 4. The transmit request output equals this flag ANDed with FIFO-control bit 3, and FIFO control is at select 2.
- R6: The receive-full flag (FIFO-status bit 0) sets one cycle after the receive count exceeds the receive threshold, which is held in bits 4:0 of the threshold word. The receive request output equals this flag ANDed with FIFO-control bit 2.
- R7: A write to the status word (select 1) or to the FIFO-status word (select 3) clears each sticky flag whose bit is written 0, and leaves alone each flag whose bit is written 1. If the set condition for a flag holds in the same cycle, the set wins.
- R8: The error interrupt is high when any error flag is high together with its enable in the control word (select 0, bits 29:26, same order as the status bits). It is also high when the idle flag (status bit 25) is set. The idle flag follows the link_idle input one cycle late.
- R9: Control bits 1 and 0 start transmit and receive, and are shown on run_tx and run_rx. An error event clears both run bits in the cycle it occurs. A control write that tries to set a run bit has no effect while any error flag is set, and takes effect once all error flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_addr | input | 3 | Word select: 0 control, 1 status, 2 FIFO control, 3 FIFO status, 4 threshold |
| wr_data | input | 32 | Write data |
| tx_push | input | 1 | Software write into the transmit FIFO |
| tx_fetch | input | 1 | Serial side fetch from the transmit FIFO |
| rx_store | input | 1 | Serial side store into the receive FIFO |
| rx_pop | input | 1 | Software read from the receive FIFO |
| link_idle | input | 1 | Serial engine reports idle |
| tx_push_ok | output | 1 | Transmit push accepted |
| tx_fetch_zero | output | 1 | Transmit fetch found the FIFO empty; send zero |
| rx_store_ok | output | 1 | Receive store accepted |
| rx_pop_zero | output | 1 | Receive read found the FIFO empty; return zero |
| stat_word | output | 32 | Error flags at 29:26, idle at 25 |
| fifo_stat_word | output | 32 | Counts and data-request flags |
| run_tx | output | 1 | Transmit started |
| run_rx | output | 1 | Receive started |
| dreq_tx | output | 1 | Transmit data request |
| dreq_rx | output | 1 | Receive data request |
| irq_err | output | 1 | Combined error and idle interrupt |

## Verification
The counts are driven with a burst of pushes, a push and a pop in the same cycle, and a run of pops. These show a counter that nets the two strobes apart from one that favours one of them. Each threshold flag is watched in the cycle the count crosses its threshold and again one cycle later, to pin down the one-cycle set latency and the at-or-below versus strictly-above comparison. Clear writes are tried in three forms: ones (no effect), zeros while the condition still holds (the set wins), and zeros after the condition has gone (the flag clears). The overflow and underflow cases then check, in turn, the forced stop, a refused restart, the interrupt masking, and a restart after the flags are cleared.

// File: rtl/afu_pkg.sv
`timescale 1ns/1ps
package afu_pkg;
  localparam int CNT_W = 6;
  localparam int THR_W = 5;
  localparam int ERR_N = 4;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_STAT  = 3'd1;
  localparam logic [2:0] SEL_FCTRL = 3'd2;
  localparam logic [2:0] SEL_FSTAT = 3'd3;
  localparam logic [2:0] SEL_THR   = 3'd4;

  localparam int ERR_LO   = 26;
  localparam int IDLE_POS = 25;
  localparam int TXC_LO   = 24;
  localparam int TE_POS   = 16;
  localparam int RXC_LO   = 8;
  localparam int RF_POS   = 0;
  localparam int TIE_POS  = 3;
  localparam int RIE_POS  = 2;
  localparam int TXT_LO   = 8;
  localparam int RXT_LO   = 0;

  function automatic logic [CNT_W-1:0] occ_step(logic [CNT_W-1:0] c, logic inc, logic dec);
    return c + CNT_W'(inc) - CNT_W'(dec);
  endfunction

  function automatic logic low_water(logic [CNT_W-1:0] c, logic [THR_W-1:0] t);
    return c <= {1'b0, t};
  endfunction

  function automatic logic high_water(logic [CNT_W-1:0] c, logic [THR_W-1:0] t);
    return c > {1'b0, t};
  endfunction
endpackage

// File: rtl/afu_occ.sv
`timescale 1ns/1ps
module afu_occ import afu_pkg::*; #(
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] count,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             ovf_evt,
  output logic             unf_evt
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic full, empty;
  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);
  assign push_ok = push & ~full;
  assign ovf_evt = push & full;
  assign pop_ok  = pop & ~empty;
  assign unf_evt = pop & empty;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= occ_step(count, push_ok, pop_ok);
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  p_drop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pop) |=> $stable(count));
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unf_evt && !push) |=> (count == '0));
endmodule

// File: rtl/afu_sticky.sv
`timescale 1ns/1ps
module afu_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_wr ? ~wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_mask) | set;
  end

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(clr_wr && !wdata[i])) |=> flags[i]);
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flags[i]);
  end
endmodule

// File: rtl/afu_irq_unit.sv
`timescale 1ns/1ps
module afu_irq_unit import afu_pkg::*; #(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        tx_push,
  input  logic        tx_fetch,
  input  logic        rx_store,
  input  logic        rx_pop,
  input  logic        link_idle,
  output logic        tx_push_ok,
  output logic        tx_fetch_zero,
  output logic        rx_store_ok,
  output logic        rx_pop_zero,
  output logic [31:0] stat_word,
  output logic [31:0] fifo_stat_word,
  output logic        run_tx,
  output logic        run_rx,
  output logic        dreq_tx,
  output logic        dreq_rx,
  output logic        irq_err
);
  logic ctrl_wr, stat_wr, fctrl_wr, fstat_wr, thr_wr;
  assign ctrl_wr  = wr_en && (wr_addr == SEL_CTRL);
  assign stat_wr  = wr_en && (wr_addr == SEL_STAT);
  assign fctrl_wr = wr_en && (wr_addr == SEL_FCTRL);
  assign fstat_wr = wr_en && (wr_addr == SEL_FSTAT);
  assign thr_wr   = wr_en && (wr_addr == SEL_THR);

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic tx_ovf, tx_unf, rx_ovf, rx_unf;
  logic tx_fetch_ok, rx_pop_ok;

  afu_occ #(.DEPTH(DEPTH)) u_tx_occ (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .pop(tx_fetch),
    .count(tx_cnt), .push_ok(tx_push_ok), .pop_ok(tx_fetch_ok),
    .ovf_evt(tx_ovf), .unf_evt(tx_unf));

  afu_occ #(.DEPTH(DEPTH)) u_rx_occ (
    .clk(clk), .rst_n(rst_n), .push(rx_store), .pop(rx_pop),
    .count(rx_cnt), .push_ok(rx_store_ok), .pop_ok(rx_pop_ok),
    .ovf_evt(rx_ovf), .unf_evt(rx_unf));

  assign tx_fetch_zero = tx_unf;
  assign rx_pop_zero   = rx_unf;

  logic unused_ok;
  assign unused_ok = tx_fetch_ok ^ rx_pop_ok;

  logic [ERR_N-1:0] err_evt, err_q, err_en_q;
  assign err_evt = {tx_unf, tx_ovf, rx_unf, rx_ovf};

  afu_sticky #(.W(ERR_N)) u_err (
    .clk(clk), .rst_n(rst_n), .set(err_evt), .clr_wr(stat_wr),
    .wdata(wr_data[ERR_LO +: ERR_N]), .flags(err_q));

  logic [THR_W-1:0] thr_tx_q, thr_rx_q;
  logic [1:0] req_set, req_q, req_en_q;
  assign req_set = {low_water(tx_cnt, thr_tx_q), high_water(rx_cnt, thr_rx_q)};

  afu_sticky #(.W(2)) u_req (
    .clk(clk), .rst_n(rst_n), .set(req_set), .clr_wr(fstat_wr),
    .wdata({wr_data[TE_POS], wr_data[RF_POS]}), .flags(req_q));

  logic [1:0] run_q;
  logic idle_q, err_block;
  assign err_block = (|err_evt) || (|err_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_en_q <= '0;
      req_en_q <= '0;
      thr_tx_q <= '0;
      thr_rx_q <= '0;
      run_q    <= '0;
      idle_q   <= 1'b0;
    end else begin
      idle_q <= link_idle;
      if (ctrl_wr)  err_en_q <= wr_data[ERR_LO +: ERR_N];
      if (fctrl_wr) req_en_q <= {wr_data[TIE_POS], wr_data[RIE_POS]};
      if (thr_wr) begin
        thr_tx_q <= wr_data[TXT_LO +: THR_W];
        thr_rx_q <= wr_data[RXT_LO +: THR_W];
      end
      if (err_block)    run_q <= '0;
      else if (ctrl_wr) run_q <= wr_data[1:0];
    end
  end

  assign run_tx  = run_q[1];
  assign run_rx  = run_q[0];
  assign dreq_tx = req_q[1] & req_en_q[1];
  assign dreq_rx = req_q[0] & req_en_q[0];
  assign irq_err = (|(err_q & err_en_q)) | idle_q;

  assign stat_word = {2'b00, err_q, idle_q, 25'd0};
  assign fifo_stat_word = {2'b00, tx_cnt, 7'd0, req_q[1], 2'b00, rx_cnt, 7'd0, req_q[0]};

  p_stop_on_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_q) |-> (run_q == 2'b00));
  p_te_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q[1]) |-> $past(tx_cnt <= {1'b0, thr_tx_q}));
  p_rf_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q[0]) |-> $past(rx_cnt > {1'b0, thr_rx_q}));
  p_idle_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_word[IDLE_POS]) |-> $past(link_idle));
endmodule

// File: tb/afu_irq_unit_test.sv
`timescale 1ns/1ps
module afu_irq_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic tx_push = 0, tx_fetch = 0, rx_store = 0, rx_pop = 0, link_idle = 0;
  logic tx_push_ok, tx_fetch_zero, rx_store_ok, rx_pop_zero;
  logic [31:0] stat_word, fifo_stat_word;
  logic run_tx, run_rx, dreq_tx, dreq_rx, irq_err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  afu_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tx_push(tx_push), .tx_fetch(tx_fetch), .rx_store(rx_store), .rx_pop(rx_pop),
    .link_idle(link_idle), .tx_push_ok(tx_push_ok), .tx_fetch_zero(tx_fetch_zero),
    .rx_store_ok(rx_store_ok), .rx_pop_zero(rx_pop_zero), .stat_word(stat_word),
    .fifo_stat_word(fifo_stat_word), .run_tx(run_tx), .run_rx(run_rx),
    .dreq_tx(dreq_tx), .dreq_rx(dreq_rx), .irq_err(irq_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  function automatic logic [5:0] txc(); return fifo_stat_word[29:24]; endfunction
  function automatic logic [5:0] rxc(); return fifo_stat_word[13:8]; endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 stat", stat_word, 0);
    chk("R1 fifo stat", fifo_stat_word, 0);
    chk("R1 outputs", {run_tx, run_rx, dreq_tx, dreq_rx, irq_err}, 0);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_counts();
    tx_push = 1;
    repeat (5) @(negedge clk);
    tx_push = 0;
    chk("R2 tx count after 5 pushes", txc(), 5);
    tx_push = 1; tx_fetch = 1;
    #1 chk("R2 push accepted", tx_push_ok, 1);
    @(negedge clk);
    tx_push = 0; tx_fetch = 0;
    chk("R2 push+pop same cycle", txc(), 5);
    tx_fetch = 1;
    repeat (2) @(negedge clk);
    tx_fetch = 0;
    chk("R2 tx count after pops", txc(), 3);
    rx_store = 1;
    repeat (4) @(negedge clk);
    rx_store = 0;
    chk("R2 rx count", rxc(), 4);
  endtask

  task automatic t_tx_thr();
    wr(3'd4, (32'd2 << 8) | 32'd4);
    wr(3'd2, 32'h0000_000C);
    wr(3'd3, 32'h0);
    chk("R7 flags cleared", {fifo_stat_word[16], fifo_stat_word[0]}, 0);
    chk("R5 no request above threshold", dreq_tx, 0);
    tx_fetch = 1;
    @(negedge clk);
    tx_fetch = 0;
    chk("R5 flag latency", fifo_stat_word[16], 0);
    @(negedge clk);
    chk("R5 flag at threshold", fifo_stat_word[16], 1);
    chk("R5 tx request", dreq_tx, 1);
    wr(3'd3, 32'h0001_0001);
    chk("R7 write one keeps", fifo_stat_word[16], 1);
    wr(3'd3, 32'h0);
    chk("R7 set wins over clear", fifo_stat_word[16], 1);
    tx_push = 1;
    repeat (2) @(negedge clk);
    tx_push = 0;
    wr(3'd3, 32'h0);
    chk("R7 clear after condition gone", fifo_stat_word[16], 0);
    chk("R5 request drops", dreq_tx, 0);
  endtask

  task automatic t_rx_thr();
    chk("R6 no flag at equal count", fifo_stat_word[0], 0);
    rx_store = 1;
    @(negedge clk);
    rx_store = 0;
    chk("R6 flag latency", fifo_stat_word[0], 0);
    @(negedge clk);
    chk("R6 flag above threshold", fifo_stat_word[0], 1);
    chk("R6 rx request", dreq_rx, 1);
    wr(3'd2, 32'h0000_0008);
    chk("R6 request masked", dreq_rx, 0);
  endtask

  task automatic t_overflow();
    wr(3'd0, 32'h3);
    chk("R9 run set", {run_tx, run_rx}, 2'b11);
    tx_push = 1;
    repeat (28) @(negedge clk);
    chk("R2 tx full count", txc(), 32);
    #1 chk("R3 push refused", tx_push_ok, 0);
    @(negedge clk);
    tx_push = 0;
    chk("R3 count unchanged", txc(), 32);
    chk("R3 overflow flag", stat_word[29:26], 4'b0100);
    chk("R9 forced stop", {run_tx, run_rx}, 2'b00);
    chk("R8 masked error", irq_err, 0);
    wr(3'd0, (32'd1 << 28) | 32'h3);
    chk("R9 restart refused", {run_tx, run_rx}, 2'b00);
    chk("R8 enabled error", irq_err, 1);
    wr(3'd1, ~(32'd1 << 28));
    chk("R7 status clear", stat_word[29:26], 0);
    chk("R8 irq after clear", irq_err, 0);
    wr(3'd0, (32'd1 << 28) | 32'h3);
    chk("R9 restart", {run_tx, run_rx}, 2'b11);
  endtask

  task automatic t_underflow();
    rx_pop = 1;
    #1 chk("R4 no zero-fill when data", rx_pop_zero, 0);
    repeat (5) @(negedge clk);
    chk("R4 rx drained", rxc(), 0);
    #1 chk("R4 zero-fill", rx_pop_zero, 1);
    @(negedge clk);
    rx_pop = 0;
    chk("R4 count stays zero", rxc(), 0);
    chk("R4 underflow flag", stat_word[29:26], 4'b0010);
    chk("R9 stop on underflow", {run_tx, run_rx}, 2'b00);
    chk("R8 other enable only", irq_err, 0);
  endtask

  task automatic t_idle();
    link_idle = 1;
    @(negedge clk);
    chk("R8 idle flag", stat_word[25], 1);
    chk("R8 idle irq", irq_err, 1);
    link_idle = 0;
    @(negedge clk);
    chk("R8 idle drop", stat_word[25], 0);
    chk("R8 irq drop", irq_err, 0);
  endtask

  initial begin
    t_reset();
    t_counts();
    t_tx_thr();
    t_rx_thr();
    t_overflow();
    t_underflow();
    t_idle();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule